// File: doc/BRIEF.md
# Battery RAM Checksum Engine

This engine computes the 16-bit integrity sum of a 256-byte battery-backed RAM. The RAM sits outside the block, behind a byte-wide request/response port. A run begins with a one-cycle `start`. The engine walks down through the RAM one byte position at a time, from position 0xFA to position 0x00. At each position it treats the byte found there as the low half of a 16-bit word, and the byte one address above as the high half. Neighbouring words therefore share a byte.

At each position the 16-bit accumulator and a carry flag are rotated left as one 17-bit quantity. The word is then added together with the carry, and the carry out of that addition is kept for the next step. At the end the block presents two values: the sum, and the sum XORed with 0xAAAA.

Two options are latched with `start`:
- **Store** writes both values into the four reserved bytes at the top of the RAM.
- **Verify** first reads those four bytes back and reports whether both stored values equal the computed ones. A mismatch means the RAM contents must be treated as invalid.

When both options are requested, verify runs before store.

The memory request port is valid/ready. While `mem_req_valid` is high and `mem_req_ready` is low, the engine holds the address, the write flag and the write data unchanged. A request transfers on a cycle where both are high. A read is answered by exactly one `mem_rsp_valid` pulse one or more cycles after the transfer. The response carries no ready signal, because the engine always accepts it. At most one read is in flight at any time. Writes get no response.

Top module: `bram_sum_engine`

## Requirements
- R1: After reset, `busy`, `done`, `match` and `mem_req_valid` are 0 and `sum_out` is 0.
- R2: `sum_out` is the result of the following walk. Start with the accumulator at 0 and the carry at 0. For each position p from 0xFA down to 0x00: rotate the 17-bit value {carry, acc} left by one; then add the word {byte[p+1], byte[p]} plus the carry, taking the carry out of that addition as the new carry.
- R3: At `done`, `sum_cpl` equals `sum_out` XOR 0xAAAA.
- R4: The walk reads each byte from 0x00 to 0xFB exactly once. The order is 0xFB first, then 0xFA, 0xF9 and so on down to 0x00, for 252 reads in all. A run with neither option issues no other request.
- R5: A request held off by `mem_req_ready` = 0 keeps its valid, address, write flag and data until it transfers.
- R6: With `op_store` set, after the walk the engine writes exactly four bytes, in this order: sum bits 7:0 to 0xFC, sum bits 15:8 to 0xFD, (sum XOR 0xAAAA) bits 7:0 to 0xFE, and bits 15:8 of the same value to 0xFF. Without `op_store` it writes nothing.
- R7: With `op_verify` set, after the walk the engine reads 0xFC to 0xFF in that order. `match` is 1 only if those bytes hold both values exactly as R6 places them; any single differing byte gives 0.
- R8: With both options set, the verify reads come before the writes, so `match` reflects the contents from before the store.
- R9: `done` is high for exactly one cycle per run. `sum_out`, `sum_cpl` and `match` then stay unchanged until the next accepted `start`.
- R10: `start`, `op_store` and `op_verify` are ignored while `busy` is high; a run is never restarted or changed by them.
- R11: A run without `op_verify` ends with `match` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; accepted only while `busy` is low |
| op_store | input | 1 | Latched at start: write the results to 0xFC..0xFF |
| op_verify | input | 1 | Latched at start: compare 0xFC..0xFF against the results |
| busy | output | 1 | A run is in progress (including the `done` cycle) |
| done | output | 1 | One-cycle pulse at the end of a run |
| sum_out | output | 16 | Computed checksum |
| sum_cpl | output | 16 | Checksum XOR 0xAAAA |
| match | output | 1 | Stored values equal computed ones (verify runs only) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | 8 | Byte address of the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_wdata | output | 8 | Write data |
| mem_rsp_valid | input | 1 | Read data valid, one pulse per accepted read |
| mem_rsp_data | input | 8 | Read data |

## Verification
The hardest cases to reach from the ports are the byte-reuse path under back-pressure and the ordering of verify against store.

For back-pressure, the bench's memory model pulls ready low on a pseudo-random three cycles in four, so many requests stall across several edges. A monitor checks that each stalled request is held unchanged, and the read log must still show the exact 0xFB, 0xFA ... 0x00 sequence.

For the ordering, the bench corrupts one stored byte and then issues a combined verify-and-store run. That run must report a mismatch and still leave correct bytes behind, which a following verify-only run then confirms.

An all-0xFF image drives the carry into every rotate and add, and a second start issued mid-run shows that options cannot leak into a run that is already under way.

// File: rtl/bram_sum_pkg.sv
package bram_sum_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_HI_REQ,
    S_HI_WAIT,
    S_LO_REQ,
    S_LO_WAIT,
    S_VF_REQ,
    S_VF_WAIT,
    S_WR_REQ,
    S_DONE
  } seq_state_t;

endpackage

// File: rtl/bram_sum_acc.sv
module bram_sum_acc #(
  parameter int SUM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [SUM_W-1:0] word,
  output logic [SUM_W-1:0] sum
);

  logic [SUM_W-1:0] acc_q;
  logic             cy_q;
  logic [SUM_W-1:0] rot;
  logic             rot_cy;
  logic [SUM_W:0]   add_res;

  // 17-bit rotate through carry, then add with the bit rotated out as carry-in
  always_comb begin
    rot     = {acc_q[SUM_W-2:0], cy_q};
    rot_cy  = acc_q[SUM_W-1];
    add_res = {1'b0, rot} + {1'b0, word} + {{SUM_W{1'b0}}, rot_cy};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
    end else if (step) begin
      acc_q <= add_res[SUM_W-1:0];
      cy_q  <= add_res[SUM_W];
    end
  end

  assign sum = acc_q;

  // R9: the result moves only on a step or a clear
  assert_acc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(sum));

endmodule

// File: rtl/bram_sum_cmp.sv
module bram_sum_cmp #(
  parameter int DATA_W = 8,
  parameter int NBYTES = 4,
  parameter logic [NBYTES*DATA_W/2-1:0] KEY = 16'hAAAA
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          capture,
  input  logic [$clog2(NBYTES)-1:0]     slot,
  input  logic [DATA_W-1:0]             rsp_data,
  input  logic [NBYTES*DATA_W/2-1:0]    sum,
  output logic                          match
);

  localparam int SUM_W = NBYTES * DATA_W / 2;
  localparam int IDX_W = $clog2(NBYTES);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NBYTES - 1);

  logic [NBYTES*DATA_W-1:0] held_q;
  logic [NBYTES*DATA_W-1:0] expect_v;
  logic [NBYTES-1:0]        eq;
  logic                     checked_q;

  assign expect_v = {sum ^ KEY, sum};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q    <= '0;
      checked_q <= 1'b0;
    end else begin
      if (clr) checked_q <= 1'b0;
      else if (capture && slot == LAST_SLOT) checked_q <= 1'b1;
      for (int b = 0; b < NBYTES; b++) begin
        if (capture && slot == IDX_W'(b)) held_q[b*DATA_W +: DATA_W] <= rsp_data;
      end
    end
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte_eq
    assign eq[g] = (held_q[g*DATA_W +: DATA_W] == expect_v[g*DATA_W +: DATA_W]);
  end

  assign match = checked_q && (&eq);

  // R11: a new run always drops a previous match
  assert_clear_drops_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !match);

  // R7: the stored sum bytes must be compared against the live result width
  initial assert (SUM_W == 2 * DATA_W);

endmodule

// File: rtl/bram_sum_seq.sv
module bram_sum_seq
  import bram_sum_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NBYTES = 4,
  parameter logic [ADDR_W-1:0] TOP_POS  = 8'hFA,
  parameter logic [ADDR_W-1:0] SUM_BASE = 8'hFC
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      op_store,
  input  logic                      op_verify,
  input  logic                      req_ready,
  input  logic                      rsp_valid,
  input  logic [DATA_W-1:0]         rsp_data,
  output logic                      req_valid,
  output logic [ADDR_W-1:0]         req_addr,
  output logic                      req_we,
  output logic                      busy,
  output logic                      done,
  output logic                      acc_clr,
  output logic                      acc_step,
  output logic [2*DATA_W-1:0]       word,
  output logic                      vf_capture,
  output logic [$clog2(NBYTES)-1:0] slot
);

  localparam int IDX_W = $clog2(NBYTES);
  localparam logic [IDX_W-1:0]  LAST_SLOT = IDX_W'(NBYTES - 1);
  localparam logic [ADDR_W-1:0] HI_ADDR   = ADDR_W'(TOP_POS + 1);

  seq_state_t          state, nxt, after_walk;
  logic [ADDR_W-1:0]   pos_q;
  logic [DATA_W-1:0]   prev_q;
  logic [IDX_W-1:0]    slot_q;
  logic                op_store_q, op_verify_q;

  always_comb begin
    if (op_verify_q)     after_walk = S_VF_REQ;
    else if (op_store_q) after_walk = S_WR_REQ;
    else                 after_walk = S_DONE;
  end

  always_comb begin
    nxt        = state;
    req_valid  = 1'b0;
    req_addr   = '0;
    req_we     = 1'b0;
    acc_clr    = 1'b0;
    acc_step   = 1'b0;
    vf_capture = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        acc_clr = 1'b1;
        nxt     = S_HI_REQ;
      end
      S_HI_REQ: begin
        req_valid = 1'b1;
        req_addr  = HI_ADDR;
        if (req_ready) nxt = S_HI_WAIT;
      end
      S_HI_WAIT: if (rsp_valid) nxt = S_LO_REQ;
      S_LO_REQ: begin
        req_valid = 1'b1;
        req_addr  = pos_q;
        if (req_ready) nxt = S_LO_WAIT;
      end
      S_LO_WAIT: if (rsp_valid) begin
        acc_step = 1'b1;
        nxt      = (pos_q == '0) ? after_walk : S_LO_REQ;
      end
      S_VF_REQ: begin
        req_valid = 1'b1;
        req_addr  = SUM_BASE + ADDR_W'(slot_q);
        if (req_ready) nxt = S_VF_WAIT;
      end
      S_VF_WAIT: if (rsp_valid) begin
        vf_capture = 1'b1;
        if (slot_q == LAST_SLOT) nxt = op_store_q ? S_WR_REQ : S_DONE;
        else                     nxt = S_VF_REQ;
      end
      S_WR_REQ: begin
        req_valid = 1'b1;
        req_we    = 1'b1;
        req_addr  = SUM_BASE + ADDR_W'(slot_q);
        if (req_ready && slot_q == LAST_SLOT) nxt = S_DONE;
      end
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      pos_q       <= '0;
      prev_q      <= '0;
      slot_q      <= '0;
      op_store_q  <= 1'b0;
      op_verify_q <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && start) begin
        op_store_q  <= op_store;
        op_verify_q <= op_verify;
      end
      // the byte just read becomes the high half of the next (lower) word
      if (state == S_HI_WAIT && rsp_valid) begin
        prev_q <= rsp_data;
        pos_q  <= TOP_POS;
      end
      if (state == S_LO_WAIT && rsp_valid) begin
        prev_q <= rsp_data;
        pos_q  <= pos_q - 1'b1;
      end
      if (state == S_IDLE) slot_q <= '0;
      else if ((state == S_VF_WAIT && rsp_valid) || (state == S_WR_REQ && req_ready))
        slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end
  end

  assign word = {prev_q, rsp_data};
  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);
  assign slot = slot_q;

  // R5: a stalled request does not move
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_we)));

  // R5: responses arrive only while a read is outstanding
  assert_rsp_expected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (state inside {S_HI_WAIT, S_LO_WAIT, S_VF_WAIT}));

  // R10: options latched at start stay put for the whole run
  assert_ops_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> ($stable(op_store_q) && $stable(op_verify_q)));

  // R4: the walk never addresses above its start position
  assert_walk_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LO_REQ) |-> (pos_q <= TOP_POS));

endmodule

// File: rtl/bram_sum_engine.sv
module bram_sum_engine #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0]   TOP_POS  = 8'hFA,
  parameter logic [ADDR_W-1:0]   SUM_BASE = 8'hFC,
  parameter logic [2*DATA_W-1:0] CPL_KEY  = 16'hAAAA
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                op_store,
  input  logic                op_verify,
  output logic                busy,
  output logic                done,
  output logic [2*DATA_W-1:0] sum_out,
  output logic [2*DATA_W-1:0] sum_cpl,
  output logic                match,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic                mem_req_we,
  output logic [DATA_W-1:0]   mem_req_wdata,
  input  logic                mem_rsp_valid,
  input  logic [DATA_W-1:0]   mem_rsp_data
);

  localparam int SUM_W  = 2 * DATA_W;
  localparam int NBYTES = 2 * SUM_W / DATA_W;
  localparam int IDX_W  = $clog2(NBYTES);

  logic               acc_clr, acc_step, vf_capture;
  logic [SUM_W-1:0]   word;
  logic [IDX_W-1:0]   slot;
  logic [2*SUM_W-1:0] out_bytes;

  bram_sum_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBYTES(NBYTES),
    .TOP_POS(TOP_POS), .SUM_BASE(SUM_BASE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_store(op_store), .op_verify(op_verify),
    .req_ready(mem_req_ready), .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data),
    .req_valid(mem_req_valid), .req_addr(mem_req_addr), .req_we(mem_req_we),
    .busy(busy), .done(done), .acc_clr(acc_clr), .acc_step(acc_step),
    .word(word), .vf_capture(vf_capture), .slot(slot)
  );

  bram_sum_acc #(.SUM_W(SUM_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .step(acc_step),
    .word(word), .sum(sum_out)
  );

  bram_sum_cmp #(.DATA_W(DATA_W), .NBYTES(NBYTES), .KEY(CPL_KEY)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .capture(vf_capture),
    .slot(slot), .rsp_data(mem_rsp_data), .sum(sum_out), .match(match)
  );

  assign sum_cpl       = sum_out ^ CPL_KEY;
  assign out_bytes     = {sum_cpl, sum_out};
  assign mem_req_wdata = out_bytes[slot*DATA_W +: DATA_W];

  // R9: done is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1: an idle engine issues no memory traffic
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  // R9: results hold while idle and not restarted
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(sum_out) && $stable(match)));

  // R5: write data of a stalled request does not move
  assert_wdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_wdata));

endmodule

// File: tb/tb_bram_sum_engine.sv
`timescale 1ns/1ps
module tb_bram_sum_engine;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, op_store, op_verify;
  logic        busy, done, match;
  logic [15:0] sum_out, sum_cpl;
  logic        req_valid, req_we, rdy;
  logic [7:0]  req_addr, req_wdata;
  logic        rsp_v;
  logic [7:0]  rsp_d;

  bram_sum_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_store(op_store), .op_verify(op_verify),
    .busy(busy), .done(done), .sum_out(sum_out), .sum_cpl(sum_cpl), .match(match),
    .mem_req_valid(req_valid), .mem_req_ready(rdy), .mem_req_addr(req_addr),
    .mem_req_we(req_we), .mem_req_wdata(req_wdata),
    .mem_rsp_valid(rsp_v), .mem_rsp_data(rsp_d)
  );

  // ---------------- memory model ----------------
  logic [7:0]  mem [256];
  logic [7:0]  lfsr = 8'h5A;
  bit          stall_en;
  int          rd_cnt, wr_cnt, hold_viol;
  logic [7:0]  rd_log [512];
  logic [15:0] wr_log [16];
  logic        stall_q;
  logic [7:0]  a_q, wd_q;
  logic        we_q;

  assign rdy = !stall_en || (lfsr[1:0] == 2'b11);

  initial begin
    rsp_v = 1'b0; rsp_d = '0; stall_q = 1'b0; a_q = '0; wd_q = '0; we_q = 1'b0;
    rd_cnt = 0; wr_cnt = 0; hold_viol = 0;
  end

  always @(posedge clk) begin
    lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rsp_v <= 1'b0;
    if (req_valid && rdy) begin
      if (req_we) begin
        mem[req_addr] <= req_wdata;
        wr_log[wr_cnt % 16] <= {req_addr, req_wdata};
        wr_cnt <= wr_cnt + 1;
      end else begin
        rsp_d <= mem[req_addr];
        rsp_v <= 1'b1;
        rd_log[rd_cnt % 512] <= req_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
    if (stall_q && !(req_valid && req_addr == a_q && req_we == we_q && req_wdata == wd_q))
      hold_viol <= hold_viol + 1;
    stall_q <= req_valid && !rdy;
    a_q     <= req_addr;
    we_q    <= req_we;
    wd_q    <= req_wdata;
  end

  // ---------------- checking helpers ----------------
  int nchk = 0, nerr = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_sum();
    logic [15:0] a;
    logic        c;
    a = '0; c = 1'b0;
    for (int p = 250; p >= 0; p--) begin
      logic [15:0] r;
      logic        rc;
      logic [16:0] t;
      r  = {a[14:0], c};
      rc = a[15];
      t  = {1'b0, r} + {1'b0, mem[p+1], mem[p]} + {16'b0, rc};
      a  = t[15:0];
      c  = t[16];
    end
    return a;
  endfunction

  task automatic fill(input int mul, input int add);
    for (int i = 0; i < 256; i++) mem[i] <= 8'(i * mul + add);
    @(negedge clk);
  endtask

  task automatic poke(input int addr, input logic [7:0] v);
    mem[addr] <= v;
    @(negedge clk);
  endtask

  logic [15:0] got_sum, got_cpl;
  logic        got_match, done_after;

  task automatic do_op(input bit st, input bit vf);
    int n;
    @(negedge clk);
    start = 1'b1; op_store = st; op_verify = vf;
    @(negedge clk);
    start = 1'b0; op_store = 1'b0; op_verify = 1'b0;
    n = 0;
    while (!done && n < 6000) begin
      @(negedge clk);
      n++;
    end
    chk("R9", "run reaches done", 32'(done), 32'd1);
    got_sum = sum_out; got_cpl = sum_cpl; got_match = match;
    @(negedge clk);
    done_after = done;
  endtask

  function automatic int order_mismatch(input int base);
    int m;
    m = 0;
    if (rd_log[base % 512] != 8'hFB) m++;
    for (int k = 0; k <= 250; k++)
      if (rd_log[(base + 1 + k) % 512] != 8'(250 - k)) m++;
    return m;
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1", "busy after reset", 32'(busy), 0);
    chk("R1", "done after reset", 32'(done), 0);
    chk("R1", "req_valid after reset", 32'(req_valid), 0);
    chk("R1", "sum after reset", 32'(sum_out), 0);
    chk("R1", "match after reset", 32'(match), 0);
  endtask

  task automatic t_calc(input string tag, input int mul, input int add, input bit stall);
    int rb, wb;
    logic [15:0] e;
    fill(mul, add);
    stall_en = stall;
    rb = rd_cnt; wb = wr_cnt;
    e = ref_sum();
    do_op(1'b0, 1'b0);
    chk("R2", {tag, " checksum"}, 32'(got_sum), 32'(e));
    chk("R3", {tag, " complement"}, 32'(got_cpl), 32'(e ^ 16'hAAAA));
    chk("R4", {tag, " read count"}, 32'(rd_cnt - rb), 252);
    chk("R4", {tag, " read order mismatches"}, 32'(order_mismatch(rb)), 0);
    chk("R6", {tag, " no writes without store"}, 32'(wr_cnt - wb), 0);
    chk("R9", {tag, " done low next cycle"}, 32'(done_after), 0);
    chk("R11", {tag, " match low without verify"}, 32'(got_match), 0);
  endtask

  task automatic t_store();
    int wb;
    logic [15:0] e, c;
    fill(29, 3);
    stall_en = 1'b1;
    wb = wr_cnt;
    e = ref_sum(); c = e ^ 16'hAAAA;
    do_op(1'b1, 1'b0);
    chk("R6", "store write count", 32'(wr_cnt - wb), 4);
    chk("R6", "write 0 addr/data", 32'(wr_log[(wb + 0) % 16]), {16'h0, 8'hFC, e[7:0]});
    chk("R6", "write 1 addr/data", 32'(wr_log[(wb + 1) % 16]), {16'h0, 8'hFD, e[15:8]});
    chk("R6", "write 2 addr/data", 32'(wr_log[(wb + 2) % 16]), {16'h0, 8'hFE, c[7:0]});
    chk("R6", "write 3 addr/data", 32'(wr_log[(wb + 3) % 16]), {16'h0, 8'hFF, c[15:8]});
    chk("R5", "stalled requests held", 32'(hold_viol), 0);
  endtask

  task automatic t_verify();
    int rb;
    logic [7:0] keep;
    rb = rd_cnt;
    do_op(1'b0, 1'b1);
    chk("R7", "match on good image", 32'(got_match), 1);
    chk("R7", "verify read count", 32'(rd_cnt - rb), 256);
    chk("R7", "verify reads 0xFC first", 32'(rd_log[(rb + 252) % 512]), 32'h0FC);
    chk("R7", "verify reads 0xFF last", 32'(rd_log[(rb + 255) % 512]), 32'h0FF);
    keep = mem[8'hFE];
    poke(8'hFE, keep ^ 8'h01);
    do_op(1'b0, 1'b1);
    chk("R7", "mismatch on complement byte", 32'(got_match), 0);
    poke(8'hFE, keep);
    keep = mem[8'hFD];
    poke(8'hFD, keep ^ 8'h80);
    do_op(1'b0, 1'b1);
    chk("R7", "mismatch on sum high byte", 32'(got_match), 0);
    poke(8'hFD, keep);
  endtask

  task automatic t_both();
    logic [15:0] e, c;
    e = ref_sum(); c = e ^ 16'hAAAA;
    poke(8'hFC, mem[8'hFC] ^ 8'hFF);
    do_op(1'b1, 1'b1);
    chk("R8", "verify sees pre-store bytes", 32'(got_match), 0);
    chk("R8", "stored image repaired", {mem[8'hFF], mem[8'hFE], mem[8'hFD], mem[8'hFC]}, {c, e});
    do_op(1'b0, 1'b1);
    chk("R8", "repaired image verifies", 32'(got_match), 1);
    repeat (15) begin
      @(negedge clk);
      if (done) got_match = 1'bx;
    end
    chk("R9", "sum held while idle", 32'(sum_out), 32'(got_sum));
    chk("R9", "match held, no stray done", 32'(match), 32'(got_match));
  endtask

  task automatic t_busy_start();
    int rb, wb, n, extra;
    fill(7, 200);
    stall_en = 1'b0;
    rb = rd_cnt; wb = wr_cnt;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    start = 1'b1; op_store = 1'b1; op_verify = 1'b1;
    @(negedge clk);
    start = 1'b0; op_store = 1'b0; op_verify = 1'b0;
    n = 0;
    while (!done && n < 6000) begin
      @(negedge clk);
      n++;
    end
    chk("R10", "checksum unaffected by mid-run start", 32'(sum_out), 32'(ref_sum()));
    chk("R10", "no store from ignored options", 32'(wr_cnt - wb), 0);
    chk("R10", "single walk only", 32'(rd_cnt - rb), 252);
    chk("R11", "no match from ignored verify", 32'(match), 0);
    extra = 0;
    repeat (40) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R10", "no second run", 32'(extra), 0);
  endtask

  // ---------------- main ----------------
  initial begin
    rst_n = 1'b0; start = 1'b0; op_store = 1'b0; op_verify = 1'b0; stall_en = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_calc("zeros", 0, 0, 1'b0);
    t_calc("ramp", 37, 5, 1'b1);
    t_calc("all-ones", 0, 255, 1'b1);
    t_store();
    t_verify();
    t_both();
    t_busy_start();
    chk("R5", "stalled requests held overall", 32'(hold_viol), 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(64'd4_000_000);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule